// File: doc/BRIEF.md
# E3 Maintenance Byte Generator

This block produces the maintenance byte carried in every outgoing E3 frame. The two far-end indication bits can come from either of two sources. The first is the condition of the receive framer on the same channel: its signal-loss, alarm-indication and frame-loss flags, and its parity-error pulses. The second is a value written by the host. The remaining six bits always come from the host register. They carry a payload type, two payload-dependent bits and a timing marker.

The transmit framer pulses `frame_strobe` once per frame. The block samples its sources on that pulse and then holds the byte steady until the next pulse, so the byte never changes partway through a frame. Parity-error pulses that arrive between two strobes are gathered into a sticky flag. That flag is consumed and cleared on each strobe.

The output side is a source paced by the strobe. `ma_valid` marks the single cycle in which a new byte first appears. There is no ready input and no back-pressure, because the consumer reads the byte at its own frame position and the byte stays put until the next strobe.

Top module: `e3_ma_gen`

## Requirements
- R1: After reset, `ma_byte` is 0x10, `ma_valid` is 0, and the host register holds 0x10. Bits 7..6 are 0 and the payload type in bits 5..3 is 010.
- R2: A host write (`cfg_wr_en` high) updates the register at the next clock edge. A value written in a strobe cycle is used from the following strobe onward.
- R3: On the edge that samples `frame_strobe` high, `ma_byte[5:0]` takes register bits 5..0. The field order is payload type in 5..3, payload-dependent bits in 2..1 and timing marker in bit 0.
- R4: With `auto_mode` low in the strobe cycle, `ma_byte[7]` (far-end alarm) and `ma_byte[6]` (far-end error) take register bits 7 and 6.
- R5: With `auto_mode` high in the strobe cycle, `ma_byte[7]` is 1 if any of `rx_los`, `rx_ais` or `rx_lof` is high in that cycle, and 0 otherwise.
- R6: With `auto_mode` high in the strobe cycle, `ma_byte[6]` is 1 if `rx_bip_err` was high in any cycle after the previous strobe cycle, up to and including this one, and 0 otherwise.
- R7: The error accumulator clears on every strobe in either mode. An error seen while in manual mode therefore does not show in the first automatic frame after a strobe.
- R8: `ma_byte` changes only on the edge after a strobe. `ma_valid` is high for exactly the cycle after each strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Host write enable for the maintenance register |
| cfg_wr_data | input | 8 | Host write data, laid out as the output byte |
| auto_mode | input | 1 | 1: far-end bits taken from receive status; 0: taken from the register |
| rx_los | input | 1 | Receive signal loss |
| rx_ais | input | 1 | Receive alarm indication |
| rx_lof | input | 1 | Receive frame loss |
| rx_bip_err | input | 1 | Receive parity-error pulse, one cycle per errored frame |
| frame_strobe | input | 1 | One-cycle pulse per outgoing frame |
| ma_byte | output | 8 | Maintenance byte for the current frame |
| ma_valid | output | 1 | High for the cycle in which a new byte first appears |

## Verification
The assertions assume `frame_strobe` is a single-cycle pulse. They also assume every input is a clean synchronous level that is known after reset, and they place no limit on how often the strobe arrives. The stimulus drives all inputs on the falling edge and uses the `frame_strobe` pulse as the only frame marker. It draws the status and error inputs at random at every density, including errors and writes that land in a strobe cycle and mode changes right next to a strobe. The directed cases cover the reset value and the leakage of errors across a mode change.

// File: rtl/ma_pkg.sv
package ma_pkg;
  localparam int MA_W = 8;
  localparam int PLD_TYPE_W = 3;
  localparam int PLD_DEP_W = 2;
  localparam int LOW_W = PLD_TYPE_W + PLD_DEP_W + 1;

  typedef struct packed {
    logic                  far_alarm;
    logic                  far_err;
    logic [PLD_TYPE_W-1:0] pld_type;
    logic [PLD_DEP_W-1:0]  pld_dep;
    logic                  tmark;
  } ma_byte_t;

  localparam ma_byte_t MA_RESET = '{far_alarm: 1'b0, far_err: 1'b0,
                                    pld_type: 3'b010, pld_dep: 2'b00, tmark: 1'b0};
endpackage

// File: rtl/ma_cfg_reg.sv
module ma_cfg_reg
  import ma_pkg::*;
#(
  parameter ma_byte_t RST_VAL = MA_RESET
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  ma_byte_t wr_data,
  output ma_byte_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= wr_data;
  end

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wr_data)); // R2
endmodule

// File: rtl/ma_err_acc.sv
module ma_err_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic err_in,
  input  logic frame_strobe,
  output logic err_frame
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen <= 1'b0;
    else if (frame_strobe) seen <= 1'b0;
    else if (err_in)       seen <= 1'b1;
  end

  assign err_frame = seen | err_in;

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> !seen); // R7
  AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_strobe && err_in) |=> seen); // R6
endmodule

// File: rtl/ma_byte_latch.sv
module ma_byte_latch
  import ma_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame_strobe,
  input  ma_byte_t next_byte,
  output ma_byte_t cur_byte,
  output logic     new_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_byte <= MA_RESET;
      new_byte <= 1'b0;
    end else begin
      new_byte <= frame_strobe;
      if (frame_strobe) cur_byte <= next_byte;
    end
  end

  AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> $stable(cur_byte)); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> !new_byte); // R8
endmodule

// File: rtl/e3_ma_gen.sv
module e3_ma_gen
  import ma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_en,
  input  logic [MA_W-1:0] cfg_wr_data,
  input  logic            auto_mode,
  input  logic            rx_los,
  input  logic            rx_ais,
  input  logic            rx_lof,
  input  logic            rx_bip_err,
  input  logic            frame_strobe,
  output logic [MA_W-1:0] ma_byte,
  output logic            ma_valid
);
  ma_byte_t reg_q, next_byte, out_byte;
  logic     err_frame, alarm_now;

  ma_cfg_reg #(.RST_VAL(MA_RESET)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
    .wr_data(ma_byte_t'(cfg_wr_data)), .q(reg_q)
  );

  ma_err_acc u_acc (
    .clk(clk), .rst_n(rst_n), .err_in(rx_bip_err),
    .frame_strobe(frame_strobe), .err_frame(err_frame)
  );

  assign alarm_now = rx_los | rx_ais | rx_lof;

  always_comb begin
    next_byte = reg_q;
    if (auto_mode) begin
      next_byte.far_alarm = alarm_now;
      next_byte.far_err   = err_frame;
    end
  end

  ma_byte_latch u_out (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
    .next_byte(next_byte), .cur_byte(out_byte), .new_byte(ma_valid)
  );

  assign ma_byte = out_byte;

  AST_LOW_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> ma_byte[LOW_W-1:0] == $past(reg_q[LOW_W-1:0])); // R3
  AST_MANUAL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && !auto_mode) |=> ma_byte[7:6] == $past(reg_q[7:6])); // R4
  AST_AUTO_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && auto_mode) |=> ma_byte[7] == $past(alarm_now)); // R5
  AST_AUTO_ERR_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && auto_mode && rx_bip_err) |=> ma_byte[6]); // R6
  AST_VALID_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> ma_valid); // R8
endmodule

// File: tb/sim_e3_ma_gen.sv
module sim_e3_ma_gen;
  logic clk = 0, rst_n = 0;
  logic cfg_wr_en = 0, auto_mode = 0, frame_strobe = 0;
  logic rx_los = 0, rx_ais = 0, rx_lof = 0, rx_bip_err = 0;
  logic [7:0] cfg_wr_data = 0, ma_byte;
  logic ma_valid;
  int checks = 0, errors = 0;
  logic [7:0] m_reg, m_byte;
  logic m_sticky, m_valid, l_strobe, l_auto;

  always #2.5 clk = ~clk;

  e3_ma_gen u0 (.clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .auto_mode(auto_mode), .rx_los(rx_los), .rx_ais(rx_ais), .rx_lof(rx_lof),
    .rx_bip_err(rx_bip_err), .frame_strobe(frame_strobe), .ma_byte(ma_byte), .ma_valid(ma_valid));

  function automatic logic [7:0] exp_byte();
    exp_byte = {l_auto ? (rx_los | rx_ais | rx_lof) : m_reg[7],
                l_auto ? (m_sticky | rx_bip_err) : m_reg[6], m_reg[5:0]};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    l_auto = auto_mode; l_strobe = frame_strobe;
    if (frame_strobe) begin m_byte = exp_byte(); m_sticky = 0; end
    else if (rx_bip_err) m_sticky = 1;
    m_valid = frame_strobe;
    if (cfg_wr_en) m_reg = cfg_wr_data;
    @(negedge clk);
    chk("R8 valid", {7'd0, ma_valid}, {7'd0, m_valid});
    if (l_strobe) begin
      chk("R3 low fields", {2'b0, ma_byte[5:0]}, {2'b0, m_byte[5:0]});
      chk(l_auto ? "R5 far alarm" : "R4 far alarm", {7'd0, ma_byte[7]}, {7'd0, m_byte[7]});
      chk(l_auto ? "R6 far error" : "R4 far error", {7'd0, ma_byte[6]}, {7'd0, m_byte[6]});
    end else chk("R2/R8 hold", ma_byte, m_byte);
  endtask

  task automatic idle();
    cfg_wr_en = 0; frame_strobe = 0; rx_bip_err = 0;
    rx_los = 0; rx_ais = 0; rx_lof = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_reg = 8'h10; m_byte = 8'h10; m_sticky = 0; m_valid = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset byte", ma_byte, 8'h10);
    chk("R1 reset valid", {7'd0, ma_valid}, 8'd0);
    rst_n = 1;
    @(negedge clk);
    frame_strobe = 1; step(); idle();
    chk("R1 reset register", ma_byte, 8'h10);
    // R2: write in a strobe cycle is used by the next strobe only
    cfg_wr_en = 1; cfg_wr_data = 8'hC7; frame_strobe = 1; step(); idle();
    chk("R2 old value kept", ma_byte, 8'h10);
    frame_strobe = 1; step(); idle();
    chk("R2 new value", ma_byte, 8'hC7);
    // R7: an error in manual mode must not leak into the next automatic frame
    cfg_wr_en = 1; cfg_wr_data = 8'h15; step(); idle();
    rx_bip_err = 1; step(); idle();
    frame_strobe = 1; step(); idle();
    auto_mode = 1; step();
    frame_strobe = 1; step(); idle();
    chk("R7 accumulator cleared", ma_byte, 8'h15);
    // R6: an error several cycles before the strobe is held
    rx_bip_err = 1; step(); idle(); step(); step();
    rx_ais = 1; frame_strobe = 1; step(); idle();
    chk("R6/R5 sticky error and alarm", ma_byte, 8'hD5);
    for (int i = 0; i < 3000; i++) begin
      cfg_wr_en = ($urandom % 6) == 0;
      cfg_wr_data = 8'($urandom);
      frame_strobe = ($urandom % 5) == 0;
      rx_bip_err = ($urandom % 7) == 0;
      rx_los = ($urandom % 9) == 0;
      rx_ais = ($urandom % 9) == 0;
      rx_lof = ($urandom % 9) == 0;
      if (($urandom % 23) == 0) auto_mode = ~auto_mode;
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule